// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a PCI function's configuration header, at byte offset 06h. It takes single-cycle event strobes from the bus interface: parity errors, aborts, system-error signalling, and whether the function was bus master. It also takes two enables from the command register. From these it keeps a set of sticky error flags. Software reads the word through a simple configuration port. It clears flags by writing ones to them, one byte lane at a time.

The remaining fields are hardwired and report the function's fixed capabilities:
- medium DEVSEL timing;
- a capabilities list is present;
- no fast back-to-back support, no UDF, and 33 MHz operation only.

Because of these fields, the word reads 0210h after reset. Events are registered on the rising clock edge and become visible on the read port right after that edge.

Top module: `pci_cfg_status`

## Requirements
- R1: After reset, a read with `cfgAddr` = 06h returns 0210h. A read at any other address returns 0000h.
- R2: Bit 15 sets when `addrParityErr` or `dataParityErr` is high at a clock edge.
- R3: Bit 14 sets only when `serrSignaled` and `serrEnable` are both high at an edge. With `serrEnable` low, `serrSignaled` leaves bit 14 at 0.
- R4: Bit 13 sets on `masterAbortRx`, and bit 12 sets on `targetAbortRx`.
- R5: Bit 11 sets on `targetAbortTx`.
- R6: Bit 8 sets only when `perrSeen`, `wasMaster` and `parityRespEnable` are all high at the same edge. If any one of them is low, bit 8 stays 0.
- R7: A sticky bit (15, 14, 13, 12, 11, 8) stays set until cleared. Idle cycles and writes of 0 to it leave it set.
- R8: A write at offset 06h clears each sticky bit whose `cfgWrData` bit is 1 and whose byte lane is enabled.
- R9: `cfgByteEn[1]` covers bits 15:8 and `cfgByteEn[0]` covers bits 7:0. A write with a lane disabled, or at an address other than 06h, clears nothing.
- R10: Bits 10:9 read 01b, bit 4 reads 1, and bits 7:5 and 3:0 read 0. Writes never change these bits.
- R11: If an event and a clearing write hit the same bit at the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrParityErr | input | 1 | Address parity error detected |
| dataParityErr | input | 1 | Data parity error detected |
| perrSeen | input | 1 | PERR asserted by any agent |
| wasMaster | input | 1 | This function was master in the current data phase |
| serrSignaled | input | 1 | This function signaled a system error |
| masterAbortRx | input | 1 | Own master cycle ended in master abort |
| targetAbortRx | input | 1 | Own master cycle ended in target abort |
| targetAbortTx | input | 1 | This function, as target, issued a target abort |
| serrEnable | input | 1 | SERR enable from the command register |
| parityRespEnable | input | 1 | Parity error response enable from the command register |
| cfgAddr | input | 8 | Configuration byte address |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgByteEn | input | 2 | Byte enables, bit 1 = upper byte |
| cfgWrData | input | 16 | Configuration write data |
| cfgRdData | output | 16 | Status word when addressed, else zero |

## Verification
The hardest case to reach is an event and a clearing write landing on the same flag at the same edge. The bench sets that up by driving a parity strobe and a ones-write to bit 15 in one cycle, then checks that the flag is still set afterwards. The gated conditions for bit 8 are also hard to cover fully. The bench drives three of the four enable combinations with one input missing each time, and only the full combination must set the flag. Lane-masked writes and writes to a neighbouring offset are placed while flags are set, so any accidental clear shows up on the read port.

// File: rtl/pci_cfg_status_pkg.sv
package pci_cfg_status_pkg;
  localparam int STICKY_N = 6;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] FIXED_VALUE = 16'h0210;

  // strobes from control to datapath; index 0 is bit 8, indices 1..5 are bits 11..15
  typedef struct packed {
    logic [STICKY_N-1:0] setMask;
    logic [STICKY_N-1:0] clrMask;
    logic                rdSel;
  } statStrobe_t;

  function automatic int stickyPos(input int idx);
    return (idx == 0) ? 8 : (10 + idx);
  endfunction
endpackage

// File: rtl/pci_cfg_status_ctl.sv
module pci_cfg_status_ctl
  import pci_cfg_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h06,
  localparam int LANES = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrParityErr,
  input  logic              dataParityErr,
  input  logic              perrSeen,
  input  logic              wasMaster,
  input  logic              serrSignaled,
  input  logic              masterAbortRx,
  input  logic              targetAbortRx,
  input  logic              targetAbortTx,
  input  logic              serrEnable,
  input  logic              parityRespEnable,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgWrEn,
  input  logic [LANES-1:0]  cfgByteEn,
  input  logic [WORD_W-1:0] cfgWrData,
  output statStrobe_t       strobe
);
  logic addrHit;
  logic wrHit;
  logic [STICKY_N-1:0] setVec;
  logic [STICKY_N-1:0] clrVec;

  assign addrHit = (cfgAddr == REG_OFFSET);
  assign wrHit   = cfgWrEn && addrHit;

  always_comb begin
    setVec    = '0;
    setVec[0] = perrSeen && wasMaster && parityRespEnable;
    setVec[1] = targetAbortTx;
    setVec[2] = targetAbortRx;
    setVec[3] = masterAbortRx;
    setVec[4] = serrSignaled && serrEnable;
    setVec[5] = addrParityErr || dataParityErr;
  end

  for (genvar i = 0; i < STICKY_N; i++) begin : g_clr
    localparam int POS = stickyPos(i);
    assign clrVec[i] = wrHit && cfgByteEn[POS/8] && cfgWrData[POS];
  end

  assign strobe.setMask = setVec;
  assign strobe.clrMask = clrVec;
  assign strobe.rdSel   = addrHit;

  assert_serr_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!serrEnable) |-> !strobe.setMask[4]);
  assert_dpe_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!wasMaster || !parityRespEnable) |-> !strobe.setMask[0]);
  assert_lane_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgByteEn[1] || !cfgWrEn || !addrHit) |-> (strobe.clrMask == '0));
endmodule

// File: rtl/pci_cfg_status_dp.sv
module pci_cfg_status_dp
  import pci_cfg_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  statStrobe_t       strobe,
  output logic [WORD_W-1:0] rdData
);
  logic [STICKY_N-1:0] stickyQ;
  logic [WORD_W-1:0]   wordVal;

  for (genvar i = 0; i < STICKY_N; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rstN)                   stickyQ[i] <= 1'b0;
      else if (strobe.setMask[i])  stickyQ[i] <= 1'b1;
      else if (strobe.clrMask[i])  stickyQ[i] <= 1'b0;
    end

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
      strobe.setMask[i] |=> stickyQ[i]);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.setMask[i] && !strobe.clrMask[i]) |=> $stable(stickyQ[i]));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrMask[i] && !strobe.setMask[i]) |=> !stickyQ[i]);
  end

  always_comb begin
    wordVal = FIXED_VALUE;
    for (int i = 0; i < STICKY_N; i++) wordVal[stickyPos(i)] = stickyQ[i];
  end

  assign rdData = strobe.rdSel ? wordVal : '0;
endmodule

// File: rtl/pci_cfg_status.sv
module pci_cfg_status
  import pci_cfg_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrParityErr,
  input  logic        dataParityErr,
  input  logic        perrSeen,
  input  logic        wasMaster,
  input  logic        serrSignaled,
  input  logic        masterAbortRx,
  input  logic        targetAbortRx,
  input  logic        targetAbortTx,
  input  logic        serrEnable,
  input  logic        parityRespEnable,
  input  logic [7:0]  cfgAddr,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgByteEn,
  input  logic [15:0] cfgWrData,
  output logic [15:0] cfgRdData
);
  statStrobe_t strobe;

  pci_cfg_status_ctl #(.ADDR_W(8), .REG_OFFSET(8'h06)) u_ctl (
    .clk(clk), .rstN(rstN),
    .addrParityErr(addrParityErr), .dataParityErr(dataParityErr),
    .perrSeen(perrSeen), .wasMaster(wasMaster), .serrSignaled(serrSignaled),
    .masterAbortRx(masterAbortRx), .targetAbortRx(targetAbortRx),
    .targetAbortTx(targetAbortTx), .serrEnable(serrEnable),
    .parityRespEnable(parityRespEnable), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .strobe(strobe)
  );

  pci_cfg_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(cfgRdData)
  );

  assert_parity_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addrParityErr || dataParityErr) |=> (cfgAddr != 8'h06 || cfgRdData[15]));
  assert_fixed_bits_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == 8'h06) |-> ((cfgRdData & 16'h06FF) == 16'h0210));
endmodule

// File: tb/pci_cfg_status_tb.sv
`timescale 1ns/100ps
module pci_cfg_status_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrParityErr = 0, dataParityErr = 0, perrSeen = 0, wasMaster = 0;
  logic serrSignaled = 0, masterAbortRx = 0, targetAbortRx = 0, targetAbortTx = 0;
  logic serrEnable = 0, parityRespEnable = 0;
  logic [7:0]  cfgAddr = 8'h06;
  logic        cfgWrEn = 0;
  logic [1:0]  cfgByteEn = 0;
  logic [15:0] cfgWrData = 0;
  logic [15:0] cfgRdData;

  always #2 clk = ~clk;

  pci_cfg_status u_dut (.*);

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t scoreQ[$];
  int vectors = 0;
  int miscompares = 0;
  logic [15:0] model = 16'h0000;  // sticky bits only
  bit finished = 0;

  // ev: [0]addrPar [1]dataPar [2]perr [3]master [4]serr [5]mAbortRx [6]tAbortRx [7]tAbortTx
  task automatic step(input logic [7:0] ev, input logic sEn, input logic pEn,
                      input logic wr, input logic [7:0] addr, input logic [1:0] be,
                      input logic [15:0] data, input string tag);
    logic [15:0] setV, clrV, laneM;
    @(negedge clk);
    {targetAbortTx, targetAbortRx, masterAbortRx, serrSignaled,
     wasMaster, perrSeen, dataParityErr, addrParityErr} = ev;
    serrEnable = sEn; parityRespEnable = pEn;
    cfgWrEn = wr; cfgAddr = addr; cfgByteEn = be; cfgWrData = data;
    setV = '0;
    setV[15] = ev[0] | ev[1];
    setV[14] = ev[4] & sEn;
    setV[13] = ev[5];
    setV[12] = ev[6];
    setV[11] = ev[7];
    setV[8]  = ev[2] & ev[3] & pEn;
    laneM = {{8{be[1]}}, {8{be[0]}}};
    clrV = (wr && addr == 8'h06) ? (data & laneM & 16'hF900) : 16'h0000;
    model = (model & ~clrV) | setV;
    @(posedge clk);
    #0.5;
    {targetAbortTx, targetAbortRx, masterAbortRx, serrSignaled,
     wasMaster, perrSeen, dataParityErr, addrParityErr} = '0;
    cfgWrEn = 0; cfgAddr = 8'h06; cfgByteEn = 0; cfgWrData = 0;
    scoreQ.push_back('{exp: model | 16'h0210, tag: tag});
  endtask

  // monitor: compares each expected item against the read port
  initial begin
    forever begin
      wait (scoreQ.size() > 0);
      #0.5;
      begin
        item_t it;
        it = scoreQ.pop_front();
        vectors++;
        if (cfgRdData !== it.exp) begin
          miscompares++;
          $display("FAIL %s: got %h expected %h", it.tag, cfgRdData, it.exp);
        end
      end
    end
  end

  task automatic directCheck(input logic [7:0] addr, input logic [15:0] exp, input string tag);
    @(negedge clk);
    cfgAddr = addr;
    #0.5;
    vectors++;
    if (cfgRdData !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, cfgRdData, exp);
    end
    cfgAddr = 8'h06;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rstN = 1'b1;
    directCheck(8'h06, 16'h0210, "R1 reset value");
    directCheck(8'h04, 16'h0000, "R1 other offset");
    // R2 parity sources, R8 clear
    step(8'h01, 0, 0, 0, 8'h06, 2'b00, 16'h0000, "R2 addr parity");
    step(8'h00, 0, 0, 1, 8'h06, 2'b10, 16'h8000, "R8 clear bit15");
    step(8'h02, 0, 0, 0, 8'h06, 2'b00, 16'h0000, "R2 data parity");
    step(8'h00, 0, 0, 1, 8'h06, 2'b01, 16'hFFFF, "R9 lower lane only");
    step(8'h00, 0, 0, 1, 8'h04, 2'b11, 16'hFFFF, "R9 other offset write");
    step(8'h00, 0, 0, 0, 8'h06, 2'b00, 16'h0000, "R7 idle hold");
    step(8'h00, 0, 0, 1, 8'h06, 2'b11, 16'h0000, "R7 write zero hold");
    step(8'h00, 0, 0, 1, 8'h06, 2'b11, 16'h8000, "R8 clear both lanes");
    // R3 serr gating
    step(8'h10, 0, 0, 0, 8'h06, 2'b00, 16'h0000, "R3 serr gated off");
    step(8'h10, 1, 0, 0, 8'h06, 2'b00, 16'h0000, "R3 serr enabled");
    step(8'h00, 0, 0, 1, 8'h06, 2'b10, 16'h4000, "R8 clear bit14");
    // R4 / R5 aborts
    step(8'h20, 0, 0, 0, 8'h06, 2'b00, 16'h0000, "R4 master abort");
    step(8'h40, 0, 0, 0, 8'h06, 2'b00, 16'h0000, "R4 target abort rx");
    step(8'h80, 0, 0, 0, 8'h06, 2'b00, 16'h0000, "R5 target abort tx");
    step(8'h00, 0, 0, 1, 8'h06, 2'b10, 16'h2000, "R8 clear bit13 only");
    step(8'h00, 0, 0, 1, 8'h06, 2'b10, 16'h1800, "R8 clear bits12-11");
    // R6 data parity qualification
    step(8'h0C, 0, 0, 0, 8'h06, 2'b00, 16'h0000, "R6 enable low");
    step(8'h04, 0, 1, 0, 8'h06, 2'b00, 16'h0000, "R6 not master");
    step(8'h08, 0, 1, 0, 8'h06, 2'b00, 16'h0000, "R6 no perr");
    step(8'h0C, 0, 1, 0, 8'h06, 2'b00, 16'h0000, "R6 all qualified");
    step(8'h00, 0, 0, 1, 8'h06, 2'b10, 16'h0100, "R8 clear bit8");
    // R10 read-only fields
    step(8'h00, 0, 0, 1, 8'h06, 2'b11, 16'hFFFF, "R10 write ones");
    step(8'h00, 0, 0, 1, 8'h06, 2'b11, 16'h0000, "R10 write zeros");
    // R11 collision
    step(8'h01, 0, 0, 1, 8'h06, 2'b11, 16'h8000, "R11 set vs clear");
    step(8'hFF, 1, 1, 1, 8'h06, 2'b11, 16'hFFFF, "R11 all events with clear");
    step(8'h00, 0, 0, 1, 8'h06, 2'b11, 16'hFFFF, "R8 clear all");
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule